// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers event pulses from the sources of a power-management companion into a sticky status register. Each source drives a single-cycle set pulse on its own input bit. The set bit stays high until software acknowledges it. A per-bit mask is combined with the status to drive one level-sensitive interrupt line. The line is high while at least one unmasked status bit is set.

Software reaches the block through a byte-wide register port. The port has an address, a write strobe and write data. Writes take one cycle and reads are combinational. The port exposes two mask bytes, two status bytes and two write-one-to-clear acknowledge bytes. It also has a device-off register, whose write restores every register of the block to its default. The serial front end that feeds the port and the logic that produces the events sit outside the block.

Top module: `irq_agg_top`

## Requirements
- R1: `irq_o` is high exactly when some bit of (status AND NOT mask) is one. It follows the registered state, so a write or an event changes it right after the clock edge that captures that write or event, and it does not change in a cycle with no write and no event.
- R2: After `rst_ni` is released, the mask reads 0x0FFF, so all twelve sources are masked. The status reads 0x0000 and `irq_o` is low.
- R3: Address 0 holds mask bits 7:0 and address 1 holds mask bits 15:8. A write to either address replaces only its own byte, and both bytes read back the stored value.
- R4: Address 2 reads status bits 7:0 and address 3 reads status bits 15:8. Writes to these two addresses change nothing.
- R5: A write to address 4 clears every status bit 7:0 whose write-data bit is one. A write to address 5 does the same for status bits 15:8. Both addresses read as zero.
- R6: A one on `evt_set_i[i]` sets status bit i, and the bit stays set until it is acknowledged. Bit 8 is the periodic tick, bit 9 the alarm match, bit 10 the clock-update error and bit 11 the power-button press. No status bit is set without an event.
- R7: When an event and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R8: Status bits 15:12 always read as zero.
- R9: A write to address 6 with data bit 0 at one restores mask 0x0FFF and status 0x0000 at the next edge. This soft reset overrides any event in the same cycle. A write with data bit 0 at zero has no effect, and address 6 reads as zero.
- R10: Address 7 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 12 | Single-cycle set pulse, one bit per source |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Level interrupt, high while an unmasked status bit is set |

## Verification
The bench builds the block with its default parameters: twelve sources, a 16-bit status and a 3-bit address. At that size it can walk every source bit through the full sequence of set, masked, unmasked, acknowledged and colliding, and it can read all eight addresses after every step. A byte-accurate model in the bench tracks mask and status, and a pseudo-random run of mixed writes, events and soft resets is compared against that model after each cycle. This reaches combinations of lane writes and device-off writes that the directed sweeps do not.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int BYTE_W = 8;

    // Register groups; each group occupies one address per byte lane.
    typedef enum logic [1:0] {
        GRP_MASK = 2'd0,
        GRP_STAT = 2'd1,
        GRP_ACK  = 2'd2,
        GRP_OFF  = 2'd3
    } reg_grp_e;

    // Address of a byte lane inside a group.
    function automatic int grp_addr(reg_grp_e grp, int lane, int n_lanes);
        return int'(grp) * n_lanes + lane;
    endfunction

endpackage

// File: rtl/irq_agg_regport.sv
module irq_agg_regport
    import irq_agg_pkg::*;
#(
    parameter int STAT_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       wr_en_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    input  logic [STAT_W-1:0]          status_i,
    input  logic [STAT_W-1:0]          mask_i,
    output logic [STAT_W/BYTE_W-1:0]   mask_wr_o,
    output logic [STAT_W/BYTE_W-1:0]   ack_wr_o,
    output logic                       soft_rst_o,
    output logic [BYTE_W-1:0]          rd_data_o
);

    localparam int NB = STAT_W / BYTE_W;

    typedef struct packed {
        logic [NB-1:0]     mask_wr;
        logic [NB-1:0]     ack_wr;
        logic              soft_rst;
        logic [BYTE_W-1:0] rd;
    } port_dec_t;

    port_dec_t dec;

    always_comb begin
        dec = '0;
        for (int l = 0; l < NB; l++) begin
            if (addr_i == ADDR_W'(grp_addr(GRP_MASK, l, NB))) begin
                dec.mask_wr[l] = wr_en_i;
                dec.rd         = mask_i[l*BYTE_W +: BYTE_W];
            end
            if (addr_i == ADDR_W'(grp_addr(GRP_STAT, l, NB))) begin
                dec.rd = status_i[l*BYTE_W +: BYTE_W];
            end
            if (addr_i == ADDR_W'(grp_addr(GRP_ACK, l, NB))) begin
                dec.ack_wr[l] = wr_en_i;
            end
        end
        if (addr_i == ADDR_W'(grp_addr(GRP_OFF, 0, NB))) begin
            dec.soft_rst = wr_en_i & wr_data_i[0];
        end
    end

    assign mask_wr_o  = dec.mask_wr;
    assign ack_wr_o   = dec.ack_wr;
    assign soft_rst_o = dec.soft_rst;
    assign rd_data_o  = dec.rd;

endmodule

// File: rtl/irq_agg_mask_reg.sv
module irq_agg_mask_reg
    import irq_agg_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter int NUM_SRC = 12
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [STAT_W/BYTE_W-1:0] lane_wr_i,
    input  logic [BYTE_W-1:0]        wr_data_i,
    input  logic                     soft_rst_i,
    output logic [STAT_W-1:0]        mask_o
);

    localparam int NB = STAT_W / BYTE_W;
    localparam logic [STAT_W-1:0] MASK_RST = STAT_W'((64'd1 << NUM_SRC) - 64'd1);

    typedef struct packed {
        logic [STAT_W-1:0] bits;
    } mask_st_t;

    mask_st_t mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (soft_rst_i) begin
            mask_d.bits = MASK_RST;
        end else begin
            for (int l = 0; l < NB; l++) begin
                if (lane_wr_i[l]) mask_d.bits[l*BYTE_W +: BYTE_W] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mask_q.bits <= MASK_RST;
        else         mask_q      <= mask_d;
    end

    assign mask_o = mask_q.bits;

    for (genvar l = 0; l < NB; l++) begin : g_lane_chk
        AST_MASK_LANE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lane_wr_i[l] && !soft_rst_i |=> mask_o[l*BYTE_W +: BYTE_W] == $past(wr_data_i))
            else $error("mask lane did not load"); // R3
        AST_MASK_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lane_wr_i[l] && !soft_rst_i |=> $stable(mask_o[l*BYTE_W +: BYTE_W]))
            else $error("mask lane changed without write"); // R3
    end

    AST_MASK_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> mask_o == MASK_RST)
        else $error("mask not restored by soft reset"); // R9

endmodule

// File: rtl/irq_agg_status_reg.sv
module irq_agg_status_reg
    import irq_agg_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter int NUM_SRC = 12
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_SRC-1:0]       set_i,
    input  logic [STAT_W/BYTE_W-1:0] ack_lane_i,
    input  logic [BYTE_W-1:0]        ack_data_i,
    input  logic                     soft_rst_i,
    output logic [STAT_W-1:0]        status_o
);

    localparam int NB = STAT_W / BYTE_W;

    typedef struct packed {
        logic [STAT_W-1:0] bits;
    } stat_st_t;

    stat_st_t          stat_d, stat_q;
    logic [STAT_W-1:0] ack_vec;
    logic [STAT_W-1:0] bit_nxt;
    logic [STAT_W-1:0] set_wide;

    assign set_wide = STAT_W'(set_i);

    always_comb begin
        ack_vec = '0;
        for (int l = 0; l < NB; l++) begin
            if (ack_lane_i[l]) ack_vec[l*BYTE_W +: BYTE_W] = ack_data_i;
        end
    end

    // Source bits: set beats acknowledge; bits above the sources stay zero.
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b < NUM_SRC) begin : g_src
            assign bit_nxt[b] = set_i[b] | (stat_q.bits[b] & ~ack_vec[b]);
        end else begin : g_rsv
            assign bit_nxt[b] = 1'b0;
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (soft_rst_i) stat_d.bits = '0;
        else            stat_d.bits = bit_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q.bits <= '0;
        else         stat_q      <= stat_d;
    end

    assign status_o = stat_q.bits;

    AST_SET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_i) && !soft_rst_i |=> (status_o[NUM_SRC-1:0] & $past(set_i)) == $past(set_i))
        else $error("event did not set status"); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ack_lane_i) && !soft_rst_i |=> (status_o & $past(ack_vec) & ~$past(set_wide)) == '0)
        else $error("acknowledge did not clear"); // R5

    AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|set_i) |=> (status_o & ~$past(status_o)) == '0)
        else $error("status bit rose without event"); // R6

    AST_STAT_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> status_o == '0)
        else $error("status not cleared by soft reset"); // R9

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter int NUM_SRC = 12,
    parameter int ADDR_W  = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_set_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    output logic [BYTE_W-1:0]  rd_data_o,
    output logic               irq_o
);

    localparam int NB       = STAT_W / BYTE_W;
    localparam int ACK_BASE = grp_addr(GRP_ACK, 0, NB);
    localparam int OFF_ADDR = grp_addr(GRP_OFF, 0, NB);

    logic [STAT_W-1:0] status_w;
    logic [STAT_W-1:0] mask_w;
    logic [NB-1:0]     mask_wr_w;
    logic [NB-1:0]     ack_wr_w;
    logic              soft_rst_w;

    irq_agg_regport #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_port (
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .status_i   (status_w),
        .mask_i     (mask_w),
        .mask_wr_o  (mask_wr_w),
        .ack_wr_o   (ack_wr_w),
        .soft_rst_o (soft_rst_w),
        .rd_data_o  (rd_data_o)
    );

    irq_agg_mask_reg #(.STAT_W(STAT_W), .NUM_SRC(NUM_SRC)) u_mask (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lane_wr_i  (mask_wr_w),
        .wr_data_i  (wr_data_i),
        .soft_rst_i (soft_rst_w),
        .mask_o     (mask_w)
    );

    irq_agg_status_reg #(.STAT_W(STAT_W), .NUM_SRC(NUM_SRC)) u_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (evt_set_i),
        .ack_lane_i (ack_wr_w),
        .ack_data_i (wr_data_i),
        .soft_rst_i (soft_rst_w),
        .status_o   (status_w)
    );

    assign irq_o = |(status_w & ~mask_w);

    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_i >= ADDR_W'(ACK_BASE) |-> rd_data_o == '0)
        else $error("write-only or unmapped address read nonzero"); // R5 R9 R10

    AST_IRQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i && !(|evt_set_i) |=> $stable(irq_o))
        else $error("interrupt moved without stimulus"); // R1

    AST_IRQ_SOFT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && addr_i == ADDR_W'(OFF_ADDR) && wr_data_i[0] |=> !irq_o)
        else $error("interrupt high after soft reset"); // R9

endmodule

// File: tb/irq_agg_top_bench.sv
`timescale 1ns/1ps
module irq_agg_top_bench;

    localparam int NS = 12;
    localparam int SW = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [7:0]    wd = '0;
    logic [7:0]    rd;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    logic [SW-1:0] m_mask = 16'h0FFF;
    logic [SW-1:0] m_stat = 16'h0000;

    always #5 clk = ~clk;

    irq_agg_top #(.STAT_W(SW), .NUM_SRC(NS), .ADDR_W(AW)) u_irq_agg_top (
        .clk_i(clk), .rst_ni(rst_n), .evt_set_i(evt), .addr_i(addr),
        .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model at posedge, release.
    task automatic step(input logic [2:0] a, input logic w, input logic [7:0] d,
                        input logic [NS-1:0] e);
        @(negedge clk);
        addr = a; we = w; wd = d; evt = e;
        @(posedge clk);
        if (w && a == 3'd6 && d[0]) begin
            m_mask = 16'h0FFF;
            m_stat = 16'h0000;
        end else begin
            if (w && a == 3'd0) m_mask[7:0]  = d;
            if (w && a == 3'd1) m_mask[15:8] = d;
            if (w && a == 3'd4) m_stat[7:0]  = m_stat[7:0]  & ~d;
            if (w && a == 3'd5) m_stat[15:8] = m_stat[15:8] & ~d;
            m_stat = m_stat | {4'h0, e};
        end
        #2;
        we = 1'b0; evt = '0; addr = 3'd7;
    endtask

    // Read all eight addresses and the interrupt against the model.
    task automatic check_state(input string req);
        for (int a = 0; a < 8; a++) begin
            logic [7:0] exp;
            case (a)
                0: exp = m_mask[7:0];
                1: exp = m_mask[15:8];
                2: exp = m_stat[7:0];
                3: exp = m_stat[15:8];
                default: exp = 8'h00;
            endcase
            addr = 3'(a);
            #0.5;
            chk(req, 32'(rd), 32'(exp));
        end
        chk(req, 32'(irq), 32'(|(m_stat & ~m_mask)));
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_state("R2");

        // Per-source sweep.
        for (int b = 0; b < NS; b++) begin
            logic [7:0] bit8;
            logic [2:0] lane;
            bit8 = 8'(1 << (b % 8));
            lane = 3'(b / 8);
            step(3'd7, 1'b0, 8'h00, NS'(1 << b));
            check_state("R6");
            chk("R1", 32'(irq), 32'd0);
            step(lane, 1'b1, 8'hFF & ~bit8, '0);
            check_state("R1");
            chk("R1", 32'(irq), 32'd1);
            step(3'd4 + lane, 1'b1, ~bit8, '0);
            check_state("R5");
            step(3'd4 + lane, 1'b1, bit8, NS'(1 << b));
            check_state("R7");
            chk("R7", 32'(irq), 32'd1);
            step(3'd4 + lane, 1'b1, bit8, '0);
            check_state("R5");
            chk("R5", 32'(irq), 32'd0);
            step(lane, 1'b1, 8'hFF, '0);
            check_state("R3");
        end

        // Reserved bits and read-only status.
        step(3'd1, 1'b1, 8'h00, '0);
        step(3'd7, 1'b0, 8'h00, 12'hFFF);
        step(3'd3, 1'b1, 8'h00, '0);
        step(3'd2, 1'b1, 8'h00, '0);
        check_state("R4");
        addr = 3'd3;
        #0.5;
        chk("R8", 32'(rd[7:4]), 32'd0);

        // Independent mask bytes.
        step(3'd0, 1'b1, 8'hA5, '0);
        step(3'd1, 1'b1, 8'h3C, '0);
        check_state("R3");
        step(3'd0, 1'b1, 8'h5A, '0);
        check_state("R3");

        // Device-off register.
        step(3'd6, 1'b1, 8'hFE, '0);
        check_state("R9");
        step(3'd6, 1'b1, 8'h01, 12'h0F0);
        check_state("R9");
        chk("R9", 32'(irq), 32'd0);
        step(3'd7, 1'b1, 8'hFF, 12'h300);
        step(3'd7, 1'b1, 8'h00, '0);
        check_state("R10");

        // Pseudo-random mixed traffic.
        lfsr = 32'hACE1_2024;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[2:0], lfsr[3], lfsr[11:4],
                 lfsr[23:12] & {NS{lfsr[24] & lfsr[25]}});
            check_state("R1");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule